// File: doc/BRIEF.md
# System Clock Source Sequencer

This block decides which clock drives a small microcontroller core and when the core is held in reset. A free-running RC clock is available almost immediately after power is applied, so the core starts on it. A PLL multiplies the crystal frequency by two. Once the PLL reports that it is locked, the block moves the core onto the PLL clock. If the PLL later loses lock, or reports that its input clock has gone missing, the block moves the core back to the RC clock. It holds the core in reset until the PLL has been locked again for a programmable number of RC cycles, and it raises a sticky flag that records an oscillator-watchdog reset event.

The change between the two asynchronous clocks uses break-before-make. Each clock has its own enable, taken through a synchronising flop and then a flop clocked on the falling edge. The enable of one clock is only requested once the enable of the other clock has been seen to be off. The RC domain is the control domain and never stops. The lock and missing-clock inputs are synchronised into the RC domain before the state machine uses them. The internal reset is asserted asynchronously and released through a reset synchroniser in the RC domain. If no lock arrives within a configurable number of RC cycles after power-on, the watchdog flag is also raised.

Top module: `sysclk_sequencer`

## Requirements
- R1: While `por_n` is low, `int_rst_n` is 0, `src_is_pll` is 0, `wdt_rst_flag` is 0, and `sys_clk` runs at the RC clock rate.
- R2: After power-on, while `pll_lock` stays low and the timeout has not expired, `sys_clk` stays at the RC rate and `src_is_pll` stays 0.
- R3: After `pll_lock` rises, and with `clk_missing` low, `sys_clk` runs at the PLL rate and `src_is_pll` reads 1 within 20 RC cycles. `src_is_pll` encodes 0 = RC and 1 = PLL.
- R4: `sys_clk` never shows a high or low phase shorter than the shorter half period of the two input clocks. The two clock enables are never on together.
- R5: When the PLL is in use and lock falls or `clk_missing` rises, `sys_clk` returns to the RC rate and `src_is_pll` reads 0 within 20 RC cycles.
- R6: The fallback in R5 pulls `int_rst_n` low at once, without waiting for a clock edge. `int_rst_n` stays low until the synchronised lock has been high, with no missing clock, for RST_HOLD (default 4) RC cycles. It then rises two RC edges later.
- R7: Entering the failure state of R5 sets `wdt_rst_flag`. The flag stays set through external resets and clears only on power-on reset.
- R8: If lock is not seen within LOCK_TIMEOUT RC cycles after power-on, `wdt_rst_flag` is set and the RC clock stays selected.
- R9: A low `ext_rst_n` drives `int_rst_n` low at once. `int_rst_n` rises within two RC edges after `ext_rst_n` returns high. The external reset changes neither the clock source nor the watchdog flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | RC oscillator clock, always running; control domain |
| pll_clk | input | 1 | PLL output clock, twice the crystal frequency |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| pll_lock | input | 1 | PLL lock indication, asynchronous |
| clk_missing | input | 1 | PLL input-clock-missing indication, asynchronous |
| sys_clk | output | 1 | Selected system clock |
| src_is_pll | output | 1 | Active source status: 0 = RC, 1 = PLL |
| int_rst_n | output | 1 | Internal reset to the core, active low |
| wdt_rst_flag | output | 1 | Sticky oscillator-watchdog reset flag |

## Verification
The assertions assume that `rc_clk` never stops. They also assume that `clk_missing` and a drop of `pll_lock` last well beyond the synchroniser depth, so that a change in the raw signal is always followed by the matching state change. They further assume that power-on reset is only applied while the RC clock is the one selected, so that a forced enable cannot cut a PLL pulse short. The bench changes every asynchronous input on a falling RC edge and holds each level for at least 20 RC cycles. It applies `por_n` again only after the fallback to RC has been confirmed.

// File: rtl/sysclk_seq_pkg.sv
package sysclk_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_BOOT = 2'd0,   // waiting for first lock, RC selected
    SEQ_RUN  = 2'd1,   // PLL selected
    SEQ_FAIL = 2'd2    // lock lost or clock missing, RC selected, reset held
  } seq_state_e;

  // True when the current count is the last one of a hold window of `hold` cycles.
  function automatic logic hold_elapsed(input int unsigned cnt, input int unsigned hold);
    return (cnt + 1) >= hold;
  endfunction

  // True once a start-up window of `limit` cycles has passed.
  function automatic logic window_expired(input int unsigned cnt, input int unsigned limit);
    return cnt >= limit;
  endfunction

endpackage

// File: rtl/sysclk_sync.sv
module sysclk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sysclk_seq_ctrl.sv
module sysclk_seq_ctrl
  import sysclk_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RST_HOLD     = 4,
  parameter int unsigned LOCK_TIMEOUT = 32000
) (
  input  logic clk,
  input  logic por_n,
  input  logic lock_raw,
  input  logic miss_raw,
  output logic lock_s,
  output logic sel_pll,
  output logic hold_rst,
  output logic run_state,
  output logic wdt_flag
);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);
  localparam int TMO_W  = $clog2(LOCK_TIMEOUT + 1);

  logic miss_s;
  seq_state_e state_q, state_d;
  logic [HOLD_W-1:0] hold_q;
  logic [TMO_W-1:0]  tmo_q;
  logic lock_ok, hold_done, tmo_done, fail_entry;

  sysclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
    .clk(clk), .rst_n(por_n), .d(lock_raw), .q(lock_s));
  sysclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_miss_sync (
    .clk(clk), .rst_n(por_n), .d(miss_raw), .q(miss_s));

  assign lock_ok   = lock_s & ~miss_s;
  assign hold_done = hold_elapsed(32'(hold_q), RST_HOLD);
  assign tmo_done  = window_expired(32'(tmo_q), LOCK_TIMEOUT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_BOOT: if (miss_s) state_d = SEQ_FAIL;
                else if (lock_s) state_d = SEQ_RUN;
      SEQ_RUN:  if (!lock_ok) state_d = SEQ_FAIL;
      SEQ_FAIL: if (lock_ok && hold_done) state_d = SEQ_RUN;
      default:  state_d = SEQ_FAIL;
    endcase
  end

  assign fail_entry = (state_d == SEQ_FAIL) && (state_q != SEQ_FAIL);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q  <= SEQ_BOOT;
      hold_q   <= '0;
      tmo_q    <= '0;
      wdt_flag <= 1'b0;
    end else begin
      state_q <= state_d;
      // reset-hold counter: only counts continuous good lock while failed
      if (state_q == SEQ_FAIL && lock_ok && !hold_done) hold_q <= hold_q + HOLD_W'(1);
      else                                              hold_q <= '0;
      // start-up lock window
      if (state_q == SEQ_BOOT && !lock_s && !tmo_done) tmo_q <= tmo_q + TMO_W'(1);
      // sticky watchdog event
      if (fail_entry || (state_q == SEQ_BOOT && tmo_done)) wdt_flag <= 1'b1;
    end
  end

  assign sel_pll   = (state_q == SEQ_RUN);
  assign run_state = (state_q == SEQ_RUN);
  assign hold_rst  = (state_q == SEQ_FAIL);
endmodule

// File: rtl/sysclk_gf_mux.sv
module sysclk_gf_mux (
  input  logic rc_clk,
  input  logic pll_clk,
  input  logic por_n,
  input  logic sel_pll,
  output logic sys_clk,
  output logic rc_on,
  output logic pll_on
);
  // leg 0 = RC (on after reset), leg 1 = PLL
  logic [1:0] leg_clk;
  logic [1:0] leg_want;
  logic [1:0] leg_on;

  assign leg_clk     = {pll_clk, rc_clk};
  assign leg_want[0] = ~sel_pll & ~leg_on[1];
  assign leg_want[1] =  sel_pll & ~leg_on[0];

  for (genvar g = 0; g < 2; g++) begin : g_leg
    localparam logic RV = (g == 0);
    logic req_q;
    logic on_q;
    // synchronising flop in the leg's own domain
    always_ff @(posedge leg_clk[g] or negedge por_n) begin
      if (!por_n) req_q <= RV;
      else        req_q <= leg_want[g];
    end
    // enable changes only while the leg clock is low
    always_ff @(negedge leg_clk[g] or negedge por_n) begin
      if (!por_n) on_q <= RV;
      else        on_q <= req_q;
    end
    assign leg_on[g] = on_q;
  end

  assign sys_clk = |(leg_clk & leg_on);
  assign rc_on   = leg_on[0];
  assign pll_on  = leg_on[1];
endmodule

// File: rtl/sysclk_rst_gen.sv
module sysclk_rst_gen #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic rc_clk,
  input  logic por_n,
  input  logic ext_rst_n,
  input  logic clk_missing,
  input  logic pll_lock,
  input  logic run_state,
  input  logic hold_rst,
  output logic int_rst_n
);
  logic clr_n;

  // immediate assertion on any reset source or on a raw lock drop while running
  assign clr_n = por_n & ext_rst_n & ~clk_missing & ~(run_state & ~pll_lock);

  sysclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rel_sync (
    .clk(rc_clk), .rst_n(clr_n), .d(~hold_rst), .q(int_rst_n));
endmodule

// File: rtl/sysclk_sequencer.sv
module sysclk_sequencer #(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned RST_HOLD     = 4,
  parameter int unsigned LOCK_TIMEOUT = 32000
) (
  input  logic rc_clk,
  input  logic pll_clk,
  input  logic por_n,
  input  logic ext_rst_n,
  input  logic pll_lock,
  input  logic clk_missing,
  output logic sys_clk,
  output logic src_is_pll,
  output logic int_rst_n,
  output logic wdt_rst_flag
);
  logic lock_s, sel_pll, hold_rst, run_state;
  logic rc_on, pll_on;

  sysclk_seq_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .RST_HOLD(RST_HOLD), .LOCK_TIMEOUT(LOCK_TIMEOUT)
  ) u_ctrl (
    .clk(rc_clk), .por_n(por_n), .lock_raw(pll_lock), .miss_raw(clk_missing),
    .lock_s(lock_s), .sel_pll(sel_pll), .hold_rst(hold_rst),
    .run_state(run_state), .wdt_flag(wdt_rst_flag));

  sysclk_gf_mux u_mux (
    .rc_clk(rc_clk), .pll_clk(pll_clk), .por_n(por_n), .sel_pll(sel_pll),
    .sys_clk(sys_clk), .rc_on(rc_on), .pll_on(pll_on));

  sysclk_rst_gen #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .rc_clk(rc_clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .clk_missing(clk_missing), .pll_lock(pll_lock), .run_state(run_state),
    .hold_rst(hold_rst), .int_rst_n(int_rst_n));

  // status reports the enable actually in force, brought back into RC domain
  sysclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stat_sync (
    .clk(rc_clk), .rst_n(por_n), .d(pll_on), .q(src_is_pll));
endmodule

// File: rtl/sysclk_sequencer_chk.sv
module sysclk_sequencer_chk (
  input logic rc_clk,
  input logic por_n,
  input logic ext_rst_n,
  input logic lock_s,
  input logic sel_pll,
  input logic hold_rst,
  input logic rc_on,
  input logic pll_on,
  input logic int_rst_n,
  input logic wdt_rst_flag
);
  // R4
  enables_exclusive_chk: assert property (@(posedge rc_clk) disable iff (!por_n)
    $onehot0({rc_on, pll_on}));

  // R5
  unlocked_uses_rc_chk: assert property (@(posedge rc_clk) disable iff (!por_n)
    !lock_s |=> !sel_pll);

  // R6
  fail_holds_reset_chk: assert property (@(posedge rc_clk) disable iff (!por_n)
    hold_rst |-> !int_rst_n);

  // R7
  wdt_flag_sticky_chk: assert property (@(posedge rc_clk) disable iff (!por_n)
    wdt_rst_flag |=> wdt_rst_flag);

  // R9
  ext_reset_passes_chk: assert property (@(posedge rc_clk) disable iff (!por_n)
    !ext_rst_n |-> !int_rst_n);
endmodule

bind sysclk_sequencer sysclk_sequencer_chk u_chk (
  .rc_clk(rc_clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .lock_s(lock_s),
  .sel_pll(sel_pll), .hold_rst(hold_rst), .rc_on(rc_on), .pll_on(pll_on),
  .int_rst_n(int_rst_n), .wdt_rst_flag(wdt_rst_flag));

// File: tb/sysclk_sequencer_bench.sv
`timescale 1ns/100ps
module sysclk_sequencer_bench;
  localparam int  TMO        = 300;
  localparam real XTAL_HALF  = 6.2;
  localparam real PLL_HALF   = XTAL_HALF / 2.0;  // PLL = 2 x crystal

  logic rc_clk = 0, pll_clk = 0;
  logic por_n = 0, ext_rst_n = 0, pll_lock = 0, clk_missing = 0;
  logic sys_clk, src_is_pll, int_rst_n, wdt_rst_flag;

  int total = 0, failed = 0;
  int sys_edges = 0;
  bit mon_en = 0, done = 0;
  realtime last_t = 0.0, min_w = 1000.0;

  always #5 rc_clk = ~rc_clk;            // 100 MHz
  always #(PLL_HALF) pll_clk = ~pll_clk;

  sysclk_sequencer #(.LOCK_TIMEOUT(TMO)) u_sysclk_sequencer (
    .rc_clk(rc_clk), .pll_clk(pll_clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .pll_lock(pll_lock), .clk_missing(clk_missing), .sys_clk(sys_clk),
    .src_is_pll(src_is_pll), .int_rst_n(int_rst_n), .wdt_rst_flag(wdt_rst_flag));

  always @(posedge sys_clk) sys_edges++;

  always @(sys_clk) begin
    if (mon_en && last_t > 0.0 && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    last_t = $realtime;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge rc_clk);
  endtask

  // sys_clk rising edges over 100 RC cycles: RC -> 100, PLL -> ~161
  task automatic rate(output int n);
    int c0;
    c0 = sys_edges;
    cyc(100);
    n = sys_edges - c0;
  endtask

  task automatic t_reset_state();
    int n;
    cyc(5);
    chk("R1 int_rst_n", int_rst_n, 0);
    chk("R1 src_is_pll", src_is_pll, 0);
    chk("R1 wdt_rst_flag", wdt_rst_flag, 0);
    rate(n);
    chk_rng("R1 sys_clk rate", n, 99, 101);
  endtask

  task automatic t_boot();
    int n;
    por_n = 1;
    mon_en = 1;
    cyc(3);
    ext_rst_n = 1;
    cyc(4);
    chk("R9 release", int_rst_n, 1);
    chk("R2 src_is_pll", src_is_pll, 0);
    rate(n);
    chk_rng("R2 sys_clk rate", n, 99, 101);
    chk("R2 wdt_rst_flag", wdt_rst_flag, 0);
  endtask

  task automatic t_lock();
    int n;
    pll_lock = 1;
    cyc(20);
    chk("R3 src_is_pll", src_is_pll, 1);
    chk("R3 int_rst_n", int_rst_n, 1);
    rate(n);
    chk_rng("R3 sys_clk rate", n, 155, 167);
  endtask

  task automatic t_ext_reset();
    ext_rst_n = 0;
    #1;
    chk("R9 async assert", int_rst_n, 0);
    cyc(3);
    chk("R9 source kept", src_is_pll, 1);
    ext_rst_n = 1;
    cyc(3);
    chk("R9 released", int_rst_n, 1);
    chk("R9 flag kept", wdt_rst_flag, 0);
  endtask

  task automatic t_missing();
    int n;
    clk_missing = 1;
    pll_lock = 0;
    #1;
    chk("R6 async assert", int_rst_n, 0);
    cyc(20);
    chk("R5 src_is_pll", src_is_pll, 0);
    chk("R7 flag set", wdt_rst_flag, 1);
    rate(n);
    chk_rng("R5 sys_clk rate", n, 99, 101);
    clk_missing = 0;
    cyc(20);
    chk("R6 held while unlocked", int_rst_n, 0);
    pll_lock = 1;
    cyc(5);
    chk("R6 hold window", int_rst_n, 0);
    cyc(7);
    chk("R6 released", int_rst_n, 1);
    cyc(15);
    chk("R3 back on PLL", src_is_pll, 1);
  endtask

  task automatic t_unlock();
    pll_lock = 0;
    #1;
    chk("R6 lock drop assert", int_rst_n, 0);
    cyc(20);
    chk("R5 fallback on unlock", src_is_pll, 0);
    ext_rst_n = 0;
    cyc(3);
    ext_rst_n = 1;
    cyc(5);
    chk("R7 sticky over ext reset", wdt_rst_flag, 1);
  endtask

  task automatic t_por_timeout();
    por_n = 0;
    cyc(3);
    chk("R7 por clears flag", wdt_rst_flag, 0);
    por_n = 1;
    cyc(TMO - 20);
    chk("R8 before timeout", wdt_rst_flag, 0);
    cyc(40);
    chk("R8 after timeout", wdt_rst_flag, 1);
    chk("R8 still RC", src_is_pll, 0);
  endtask

  initial begin
    t_reset_state();
    t_boot();
    t_lock();
    t_ext_reset();
    t_missing();
    t_unlock();
    t_por_timeout();
    total++;
    if (min_w < PLL_HALF - 0.2) begin
      failed++;
      $display("FAIL R4 narrowest sys_clk phase: actual %0.2f expected >= %0.2f", min_w, PLL_HALF - 0.2);
    end
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule